// File: doc/BRIEF.md
# Bus Cycle Controller With Dynamic Sizing

This block is a bus master for a 32-bit external bus. An internal client places one read or write request on its inputs: a word address, a four-bit byte mask, write data, a write flag and two cycle-kind flags. The client holds the request steady until the block answers with a one-clock `done` pulse, and drops `req_valid` in the clock where `done` is seen. The block runs the external cycle. It drives the word address, four active-low byte enables, the cycle-kind outputs and an active-low address strobe. It then waits in the data phase until the active-low ready input is sampled low.

A device that can only move 16 bits signals this on the active-low `bs16_n` input during the first data clock of a cycle. If the request enables bytes in both halves of the word, the block follows with a second cycle at the same address. That cycle enables only the upper bytes and carries them on data bits 15:0. A read's result is built from the low halves of the two cycles. While another master requests the bus on `hold`, the block finishes its current transfer, acknowledges on `hlda` and releases its outputs through output-enable signals.

The control is a four-state machine. IDLE waits for work. ADDR is the single strobe clock. DATA waits for ready. GRANT is the released bus.
- IDLE→GRANT is taken on hold.
- IDLE→ADDR is taken on a request, with hold taking priority.
- ADDR→DATA is always taken.
- DATA→DATA is taken while ready is high.
- DATA→ADDR is the split step.
- DATA→IDLE or DATA→GRANT ends the transfer.
- GRANT→IDLE is taken when hold drops.

Top module: `buscyc_ctrl`

## Requirements
- R1: After reset, `ads_n` is 1, `hlda` is 0, `done` is 0, `bus_oe` is 1 and `data_oe` is 0.
- R2: `ads_n` is 0 for exactly one clock at the start of every cycle. In that clock and through the data phase, `addr_o` equals the request word address, `be_n_o` is the inverted byte mask (bit i low enables byte lane i, data bits 8i+7:8i), `wr_o` is the write flag, `mio_o` is the memory flag and `dc_o` is the data flag.
- R3: A cycle ends only at a clock edge where `rdy_n` is sampled 0. Each data clock with `rdy_n` at 1 adds one wait state. `done` rises in the clock that follows the edge ending the last cycle.
- R4: For a write, `data_o` carries the write data and `data_oe` is 1 during the strobe and data clocks. For a read, `data_oe` stays 0.
- R5: On a single-cycle read, `rdata` equals `din` as sampled at the ending edge.
- R6: When `bs16_n` is 0 at the end of the first data clock and the mask has bytes in both lanes 1:0 and lanes 3:2, the first cycle ends without `done`. It is followed at once by a second strobe at the same address, with `be_n_o` showing only the upper mask bits (lower two bits 1).
- R7: In the second cycle of a split write, `data_o[15:0]` carries write data bits 31:16.
- R8: A split read returns `{din[15:0] of the second cycle, din[15:0] of the first cycle}`.
- R9: `bs16_n` is ignored after the first data clock of a cycle. A late assertion causes no split.
- R10: A request with bytes in only one half runs as one cycle even when `bs16_n` is 0.
- R11: With `hold` at 1 in IDLE, `hlda` is 1 from the next clock. While `hlda` is 1, `bus_oe` and `data_oe` are 0, no strobe occurs and a pending request waits. After `hold` falls, the request runs.
- R12: A `hold` raised during a transfer lets both cycles of a split finish. `hlda` then rises in the same clock as `done`.
- R13: `done` lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until `done` |
| req_addr | input | ADDR_W-2 | Word address of the request |
| req_mask | input | DATA_W/8 | Byte mask, bit i selects lane i |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 for write, 0 for read |
| req_mem | input | 1 | 1 for memory space, 0 for I/O |
| req_dat | input | 1 | 1 for data access, 0 for control |
| din | input | DATA_W | External data bus, read side |
| rdy_n | input | 1 | Active-low cycle end |
| bs16_n | input | 1 | Active-low 16-bit device indication |
| hold | input | 1 | Bus request from another master |
| addr_o | output | ADDR_W-2 | External word address |
| be_n_o | output | DATA_W/8 | Active-low byte enables |
| wr_o | output | 1 | Write/read cycle kind |
| mio_o | output | 1 | Memory/IO cycle kind |
| dc_o | output | 1 | Data/control cycle kind |
| ads_n | output | 1 | Active-low address strobe |
| data_o | output | DATA_W | External data bus, write side |
| data_oe | output | 1 | Drive enable for `data_o` |
| bus_oe | output | 1 | Drive enable for address, enables and cycle kind |
| hlda | output | 1 | Hold acknowledge |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Read result, valid with `done` |

## Verification
The properties assume that the client keeps a request steady until `done` and drops it in that clock. They also assume that `hold`, `rdy_n` and `bs16_n` change only between edges. The bench drives every input on the falling edge, so each value is settled before the rising edge samples it. The device model drives `rdy_n` low only inside a data phase, after it has seen the strobe. It returns `rdy_n` to 1 right after the ending edge, so ready never leaks into a later cycle. `hold` is raised only in IDLE or after a strobe has been observed, and is kept up until `hlda` has been checked.

// File: rtl/buscyc_pkg.sv
package buscyc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DATA  = 2'd2,
        ST_GRANT = 2'd3
    } bus_state_e;
endpackage

// File: rtl/buscyc_fsm.sv
module buscyc_fsm
    import buscyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid_i,
    input  logic       hold_i,
    input  logic       rdy_n_i,
    input  logic       bs16_n_i,
    input  logic       both_halves_i,
    output bus_state_e state_o,
    output logic       half_o,
    output logic       load_o,
    output logic       split_o,
    output logic       finish_o
);
    bus_state_e state_q, state_n;
    logic       first_q;
    logic       bs16_q;
    logic       half_q;
    logic       eff16;
    logic       at_end;

    // Width of the device is judged only in the first data clock.
    always_comb begin
        eff16    = first_q ? ~bs16_n_i : bs16_q;
        at_end   = (state_q == ST_DATA) && !rdy_n_i;
        split_o  = at_end && eff16 && !half_q && both_halves_i;
        finish_o = at_end && !split_o;
        load_o   = (state_q == ST_IDLE) && !hold_i && req_valid_i;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_i)           state_n = ST_GRANT;
                else if (req_valid_i) state_n = ST_ADDR;
            end
            ST_ADDR:  state_n = ST_DATA;
            ST_DATA: begin
                if (split_o)       state_n = ST_ADDR;
                else if (finish_o) state_n = hold_i ? ST_GRANT : ST_IDLE;
            end
            ST_GRANT: begin
                if (!hold_i) state_n = ST_IDLE;
            end
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
            bs16_q  <= 1'b0;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            first_q <= (state_q == ST_ADDR);
            if ((state_q == ST_DATA) && first_q) bs16_q <= ~bs16_n_i;
            if (load_o)       half_q <= 1'b0;
            else if (split_o) half_q <= 1'b1;
        end
    end

    assign state_o = state_q;
    assign half_o  = half_q;
endmodule

// File: rtl/buscyc_lanes.sv
module buscyc_lanes #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W/8-1:0] mask_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                half_i,
    input  logic [DATA_W-1:0]   din_i,
    input  logic [DATA_W/2-1:0] lo_i,
    output logic [DATA_W/8-1:0] be_n_o,
    output logic [DATA_W-1:0]   dout_o,
    output logic [DATA_W-1:0]   rd_o,
    output logic                both_halves_o
);
    localparam int LANES = DATA_W / 8;
    localparam int HALF  = LANES / 2;
    localparam int HW    = DATA_W / 2;

    assign both_halves_o = (|mask_i[HALF-1:0]) && (|mask_i[LANES-1:HALF]);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < HALF) begin : g_low
            // Second cycle: low lanes are off and carry the upper bytes.
            assign be_n_o[i]         = half_i ? 1'b1 : ~mask_i[i];
            assign dout_o[i*8 +: 8]  = half_i ? wdata_i[(i+HALF)*8 +: 8]
                                              : wdata_i[i*8 +: 8];
        end else begin : g_high
            assign be_n_o[i]         = ~mask_i[i];
            assign dout_o[i*8 +: 8]  = wdata_i[i*8 +: 8];
        end
    end

    assign rd_o = half_i ? {din_i[HW-1:0], lo_i} : din_i;
endmodule

// File: rtl/buscyc_ctrl.sv
module buscyc_ctrl
    import buscyc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-3:0]   req_addr,
    input  logic [DATA_W/8-1:0] req_mask,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_write,
    input  logic                req_mem,
    input  logic                req_dat,
    input  logic [DATA_W-1:0]   din,
    input  logic                rdy_n,
    input  logic                bs16_n,
    input  logic                hold,
    output logic [ADDR_W-3:0]   addr_o,
    output logic [DATA_W/8-1:0] be_n_o,
    output logic                wr_o,
    output logic                mio_o,
    output logic                dc_o,
    output logic                ads_n,
    output logic [DATA_W-1:0]   data_o,
    output logic                data_oe,
    output logic                bus_oe,
    output logic                hlda,
    output logic                done,
    output logic [DATA_W-1:0]   rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int HW    = DATA_W / 2;

    bus_state_e          state;
    logic                half, load, split, finish, both;
    logic [ADDR_W-3:0]   addr_q;
    logic [LANES-1:0]    mask_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                write_q, mem_q, dat_q;
    logic [HW-1:0]       lo_q;
    logic                done_q;
    logic [DATA_W-1:0]   rdata_q;
    logic [LANES-1:0]    be_lanes;
    logic [DATA_W-1:0]   dout_lanes;
    logic [DATA_W-1:0]   rd_full;
    logic                in_cycle;

    buscyc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .hold_i       (hold),
        .rdy_n_i      (rdy_n),
        .bs16_n_i     (bs16_n),
        .both_halves_i(both),
        .state_o      (state),
        .half_o       (half),
        .load_o       (load),
        .split_o      (split),
        .finish_o     (finish)
    );

    buscyc_lanes #(.DATA_W(DATA_W)) u_lanes (
        .mask_i       (mask_q),
        .wdata_i      (wdata_q),
        .half_i       (half),
        .din_i        (din),
        .lo_i         (lo_q),
        .be_n_o       (be_lanes),
        .dout_o       (dout_lanes),
        .rd_o         (rd_full),
        .both_halves_o(both)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            mem_q   <= 1'b0;
            dat_q   <= 1'b0;
            lo_q    <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (load) begin
                addr_q  <= req_addr;
                mask_q  <= req_mask;
                wdata_q <= req_wdata;
                write_q <= req_write;
                mem_q   <= req_mem;
                dat_q   <= req_dat;
            end
            if (split)  lo_q    <= din[HW-1:0];
            if (finish) rdata_q <= rd_full;
            done_q <= finish;
        end
    end

    always_comb begin
        in_cycle = (state == ST_ADDR) || (state == ST_DATA);
        ads_n    = (state != ST_ADDR);
        hlda     = (state == ST_GRANT);
        bus_oe   = (state != ST_GRANT);
        data_oe  = write_q && in_cycle;
        addr_o   = addr_q;
        be_n_o   = in_cycle ? be_lanes : '1;
        data_o   = dout_lanes;
        wr_o     = write_q;
        mio_o    = mem_q;
        dc_o     = dat_q;
        done     = done_q;
        rdata    = rdata_q;
    end
endmodule

// File: rtl/buscyc_chk.sv
module buscyc_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ads_n,
    input logic [ADDR_W-3:0]   addr_o,
    input logic [DATA_W/8-1:0] be_n_o,
    input logic                wr_o,
    input logic                done,
    input logic                rdy_n,
    input logic                hlda,
    input logic                hold,
    input logic                bus_oe,
    input logic                data_oe
);
    assert_strobe_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);

    assert_stable_in_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ($stable(addr_o) && $stable(be_n_o) && $stable(wr_o)));

    assert_end_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!rdy_n));

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_float_on_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!bus_oe && !data_oe && ads_n));

    assert_grant_after_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(hold));
endmodule

bind buscyc_ctrl buscyc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ads_n  (ads_n),
    .addr_o (addr_o),
    .be_n_o (be_n_o),
    .wr_o   (wr_o),
    .done   (done),
    .rdy_n  (rdy_n),
    .hlda   (hlda),
    .hold   (hold),
    .bus_oe (bus_oe),
    .data_oe(data_oe)
);

// File: tb/buscyc_ctrl_tb_top.sv
`timescale 1ns/1ps
module buscyc_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [29:0] req_addr = '0;
    logic [3:0]  req_mask = '0;
    logic [31:0] req_wdata = '0;
    logic        req_write = 1'b0, req_mem = 1'b0, req_dat = 1'b0;
    logic [31:0] din = '0;
    logic        rdy_n = 1'b1, bs16_n = 1'b1, hold = 1'b0;
    logic [29:0] addr_o;
    logic [3:0]  be_n_o;
    logic        wr_o, mio_o, dc_o, ads_n, data_oe, bus_oe, hlda, done;
    logic [31:0] data_o, rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    buscyc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_mask(req_mask), .req_wdata(req_wdata), .req_write(req_write),
        .req_mem(req_mem), .req_dat(req_dat), .din(din), .rdy_n(rdy_n),
        .bs16_n(bs16_n), .hold(hold), .addr_o(addr_o), .be_n_o(be_n_o),
        .wr_o(wr_o), .mio_o(mio_o), .dc_o(dc_o), .ads_n(ads_n),
        .data_o(data_o), .data_oe(data_oe), .bus_oe(bus_oe), .hlda(hlda),
        .done(done), .rdata(rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog R3 actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [29:0] a, input logic [3:0] m,
                         input logic [31:0] wd, input logic w);
        req_addr = a; req_mask = m; req_wdata = wd; req_write = w;
        req_mem = 1'b1; req_dat = ~w;
        req_valid = 1'b1;
    endtask

    // Device model: one external cycle, returns at the negedge after the end edge.
    task automatic bus_cycle(input int waits, input logic bs_first, input logic bs_late,
                             input logic [31:0] rd,
                             output logic [29:0] a, output logic [3:0] be,
                             output logic [31:0] wd, output logic w, output logic oe);
        int guard = 0;
        while (ads_n && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        if (ads_n) chk("R2 strobe seen", {31'd0, ads_n}, 32'd0);
        a = addr_o; be = be_n_o; w = wr_o; oe = data_oe;
        chk("R2 mio", {31'd0, mio_o}, 32'd1);
        chk("R2 dc", {31'd0, dc_o}, {31'd0, ~w});
        @(negedge clk);
        wd = data_o;
        din = rd;
        for (int i = 0; i <= waits; i++) begin
            if (i > 0) begin
                chk("R3 wait holds cycle ads", {31'd0, ads_n}, 32'd1);
                chk("R3 wait holds cycle done", {31'd0, done}, 32'd0);
            end
            rdy_n  = (i != waits);
            bs16_n = ~((i == 0) ? bs_first : bs_late);
            @(negedge clk);
        end
        rdy_n = 1'b1; bs16_n = 1'b1;
    endtask

    task automatic finish_req(input logic [31:0] exp_rd, input logic is_read, input string tag);
        chk({tag, " done"}, {31'd0, done}, 32'd1);
        if (is_read) chk({tag, " rdata"}, rdata, exp_rd);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R13 done one clock", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 ads", {31'd0, ads_n}, 32'd1);
        chk("R1 hlda", {31'd0, hlda}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 bus_oe", {31'd0, bus_oe}, 32'd1);
        chk("R1 data_oe", {31'd0, data_oe}, 32'd0);
    endtask

    task automatic t_write32();
        logic [29:0] a; logic [3:0] be; logic [31:0] wd; logic w, oe;
        issue(30'h1234567, 4'hF, 32'hA1B2C3D4, 1'b1);
        bus_cycle(0, 1'b0, 1'b0, 32'h0, a, be, wd, w, oe);
        chk("R2 addr", {2'b0, a}, {2'b0, 30'h1234567});
        chk("R2 be", {28'd0, be}, 32'h0);
        chk("R2 wr", {31'd0, w}, 32'd1);
        chk("R4 write oe", {31'd0, oe}, 32'd1);
        chk("R4 write data", wd, 32'hA1B2C3D4);
        finish_req(32'h0, 1'b0, "R3 write");
    endtask

    task automatic t_read_wait();
        logic [29:0] a; logic [3:0] be; logic [31:0] wd; logic w, oe;
        issue(30'h0000ABC, 4'b0101, 32'h0, 1'b0);
        bus_cycle(2, 1'b0, 1'b0, 32'h55667788, a, be, wd, w, oe);
        chk("R2 read be", {28'd0, be}, {28'd0, 4'b1010});
        chk("R4 read no drive", {31'd0, oe}, 32'd0);
        finish_req(32'h55667788, 1'b1, "R5 read");
    endtask

    task automatic t_write_split();
        logic [29:0] a; logic [3:0] be; logic [31:0] wd; logic w, oe;
        issue(30'h0000100, 4'hF, 32'h11223344, 1'b1);
        bus_cycle(0, 1'b1, 1'b0, 32'h0, a, be, wd, w, oe);
        chk("R6 first be", {28'd0, be}, 32'h0);
        chk("R6 no done after first", {31'd0, done}, 32'd0);
        chk("R6 second strobe", {31'd0, ads_n}, 32'd0);
        bus_cycle(1, 1'b1, 1'b1, 32'h0, a, be, wd, w, oe);
        chk("R6 second addr", {2'b0, a}, {2'b0, 30'h0000100});
        chk("R6 second be", {28'd0, be}, {28'd0, 4'b0011});
        chk("R7 upper on low lanes", {16'd0, wd[15:0]}, 32'h00001122);
        finish_req(32'h0, 1'b0, "R7 split write");
    endtask

    task automatic t_read_split();
        logic [29:0] a; logic [3:0] be; logic [31:0] wd; logic w, oe;
        issue(30'h0000200, 4'b0110, 32'h0, 1'b0);
        bus_cycle(1, 1'b1, 1'b1, 32'h0000AABB, a, be, wd, w, oe);
        chk("R6 read no done after first", {31'd0, done}, 32'd0);
        bus_cycle(0, 1'b0, 1'b0, 32'h0000CCDD, a, be, wd, w, oe);
        chk("R6 read second be", {28'd0, be}, {28'd0, 4'b1011});
        finish_req(32'hCCDDAABB, 1'b1, "R8 split read");
    endtask

    task automatic t_bs16_late();
        logic [29:0] a; logic [3:0] be; logic [31:0] wd; logic w, oe;
        issue(30'h0000300, 4'hF, 32'h0, 1'b0);
        bus_cycle(1, 1'b0, 1'b1, 32'h9ABCDEF0, a, be, wd, w, oe);
        finish_req(32'h9ABCDEF0, 1'b1, "R9 late size ignored");
    endtask

    task automatic t_upper_only();
        logic [29:0] a; logic [3:0] be; logic [31:0] wd; logic w, oe;
        issue(30'h0000400, 4'b1100, 32'hBEEF0000, 1'b1);
        bus_cycle(0, 1'b1, 1'b0, 32'h0, a, be, wd, w, oe);
        chk("R10 be", {28'd0, be}, {28'd0, 4'b0011});
        finish_req(32'h0, 1'b0, "R10 single cycle");
    endtask

    task automatic t_hold_idle();
        logic [29:0] a; logic [3:0] be; logic [31:0] wd; logic w, oe;
        hold = 1'b1;
        @(negedge clk);
        chk("R11 hlda", {31'd0, hlda}, 32'd1);
        chk("R11 bus float", {31'd0, bus_oe}, 32'd0);
        issue(30'h0000500, 4'hF, 32'h0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11 request waits", {31'd0, ads_n}, 32'd1);
            chk("R11 still granted", {31'd0, hlda}, 32'd1);
        end
        hold = 1'b0;
        bus_cycle(0, 1'b0, 1'b0, 32'h01020304, a, be, wd, w, oe);
        chk("R11 resumed addr", {2'b0, a}, {2'b0, 30'h0000500});
        chk("R11 hlda released", {31'd0, hlda}, 32'd0);
        finish_req(32'h01020304, 1'b1, "R11 resumed read");
    endtask

    task automatic t_hold_during();
        logic [29:0] a; logic [3:0] be; logic [31:0] wd; logic w, oe;
        issue(30'h0000600, 4'hF, 32'hCAFEF00D, 1'b1);
        while (ads_n) @(negedge clk);
        hold = 1'b1;
        bus_cycle(0, 1'b1, 1'b0, 32'h0, a, be, wd, w, oe);
        chk("R12 split not broken hlda", {31'd0, hlda}, 32'd0);
        chk("R12 split not broken ads", {31'd0, ads_n}, 32'd0);
        bus_cycle(0, 1'b0, 1'b0, 32'h0, a, be, wd, w, oe);
        chk("R12 upper data", {16'd0, wd[15:0]}, 32'h0000CAFE);
        chk("R12 hlda with done", {31'd0, hlda}, 32'd1);
        finish_req(32'h0, 1'b0, "R12 hold after transfer");
        hold = 1'b0;
        @(negedge clk);
        chk("R12 hlda drops", {31'd0, hlda}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write32();
        t_read_wait();
        t_write_split();
        t_read_split();
        t_bs16_late();
        t_upper_only();
        t_hold_idle();
        t_hold_during();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule